// File: doc/BRIEF.md
# RGB to YIQ Composite Encoder

This block is the color-space stage of a composite and S-video encoder. Each clock it takes a pixel as three 4-bit components, red, green and blue, along with three control flags: active video, color burst and an active-low sync. One rising edge later it presents an unsigned 12-bit luma value and two signed 12-bit chroma values, in-phase and quadrature. A later modulator turns the chroma pair into the subcarrier signal. That modulator, the DAC and the sync timing are outside this block.

All nine weights are small unsigned integers. A negative weight is applied by subtracting its product in the final sum. The red and green weights for luma and in-phase run through two dual unsigned 8x8 multipliers, with each 16-bit result truncated to 12 bits. The quadrature red term reuses the luma red product. The blue weights and the quadrature green weight are built from shifted additions only.

The control flags act only after the products exist. The register input selects among the computed sums, the blank level, the sync level and fixed burst constants. No flag gates a multiplier operand.

Top module: `rgb_yiq_encoder`

## Requirements
- R1: Every output is registered. A change on any input appears at the outputs after the next rising clock edge and not earlier.
- R2: While `rst_n` is low at a rising edge (synchronous reset), the block loads 0 into `luma`, `chroma_i` and `chroma_q`.
- R3: The mode is the 2-bit value {`active`,`burst`}. In mode 2'b10, `luma` = 27·R + 52·G + 10·B + 640.
- R4: In mode 2'b10, `chroma_i` = 76·R − 35·G − 41·B, written as 12-bit two's complement.
- R5: In mode 2'b10, `chroma_q` = 27·R − 66·G + 40·B, written as 12-bit two's complement.
- R6: In mode 2'b00, `chroma_i` and `chroma_q` are 0. `luma` is 544 when `sync_n` is 1 and 0 when `sync_n` is 0.
- R7: In mode 2'b01, `luma` follows the R6 rule. `chroma_i` = 369 and `chroma_q` = −351, which are the R4 and R5 results for R=9, G=9, B=0.
- R8: In mode 2'b11, the outputs are `luma` = 1351, `chroma_i` = 369 and `chroma_q` = −351, whatever the pixel inputs are.
- R9: In modes 2'b10 and 2'b11, `sync_n` has no effect on any output.
- R10: In modes 2'b00, 2'b01 and 2'b11, the pixel inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| red | input | 4 | Red component |
| green | input | 4 | Green component |
| blue | input | 4 | Blue component |
| active | input | 1 | Active-video flag |
| burst | input | 1 | Color-burst flag |
| sync_n | input | 1 | Sync flag, active low |
| luma | output | 12 | Registered luma, unsigned |
| chroma_i | output | 12 | Registered in-phase chroma, signed |
| chroma_q | output | 12 | Registered quadrature chroma, signed |

## Verification
The assertions check the following on every cycle:
- the cleared outputs after reset;
- the blank and sync levels, with zero chroma, in mode 00;
- the fixed burst chroma in mode 01;
- the full burst constant set in mode 11;
- the luma floor and ceiling in active video.

Only the bench can show that each active-video sum is exactly correct and that the inputs R9 and R10 name have no effect. It does this by comparing all 4096 pixel values under all eight flag combinations against a model that applies signed weights by direct multiplication.

// File: rtl/rgb_yiq_pkg.sv
package rgb_yiq_pkg;

  typedef enum logic [1:0] {
    MODE_BLANK      = 2'b00,
    MODE_BURST      = 2'b01,
    MODE_ACTIVE     = 2'b10,
    MODE_ACT_BURST  = 2'b11
  } yiq_mode_e;

  // Constant multiply built as a sum of shifted copies of x, one per set bit of k.
  function automatic int unsigned shift_add_mul(input int unsigned k, input int unsigned x);
    int unsigned acc;
    acc = 0;
    for (int n = 0; n < 16; n++) begin
      if (k[n]) acc = acc + (x << n);
    end
    return acc;
  endfunction

  // Signed three-term weighted sum, used for constant levels.
  function automatic int weighted3(input int wr, input int wg, input int wb,
                                   input int r, input int g, input int b);
    return wr * r + wg * g + wb * b;
  endfunction

endpackage

// File: rtl/yiq_mult_pair.sv
module yiq_mult_pair #(
  parameter int COMP_W = 4,
  parameter int MUL_W  = 8,
  parameter int OUT_W  = 12
) (
  input  logic [MUL_W-1:0]  coef_a,
  input  logic [MUL_W-1:0]  coef_b,
  input  logic [COMP_W-1:0] sample,
  output logic [OUT_W-1:0]  prod_a,
  output logic [OUT_W-1:0]  prod_b
);

  localparam int FULL_W = 2 * MUL_W;
  localparam int LANES  = 2;

  logic [MUL_W-1:0] coef_lane [LANES];
  logic [OUT_W-1:0] prod_lane [LANES];
  logic [MUL_W-1:0] operand;

  assign operand      = MUL_W'(sample);
  assign coef_lane[0] = coef_a;
  assign coef_lane[1] = coef_b;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      // Full 8x8 unsigned multiply, result truncated to the output width.
      assign prod_lane[l] = OUT_W'({{MUL_W{1'b0}}, coef_lane[l]} *
                                   {{MUL_W{1'b0}}, operand});
    end
  endgenerate

  assign prod_a = prod_lane[0];
  assign prod_b = prod_lane[1];

  initial begin
    if (FULL_W < OUT_W) $error("multiplier result narrower than output");
  end

endmodule

// File: rtl/yiq_const_terms.sv
module yiq_const_terms
  import rgb_yiq_pkg::*;
#(
  parameter int COMP_W = 4,
  parameter int OUT_W  = 12,
  parameter int Y_B    = 10,
  parameter int Q_B    = 40,
  parameter int I_B    = 41,
  parameter int Q_G    = 66
) (
  input  logic [COMP_W-1:0] green,
  input  logic [COMP_W-1:0] blue,
  output logic [OUT_W-1:0]  yb_prod,
  output logic [OUT_W-1:0]  qb_prod,
  output logic [OUT_W-1:0]  ib_prod,
  output logic [OUT_W-1:0]  qg_prod
);

  logic [OUT_W-1:0] blue_ext;
  assign blue_ext = OUT_W'(blue);

  assign yb_prod = OUT_W'(shift_add_mul(Y_B, int'(blue)));
  assign qb_prod = OUT_W'(shift_add_mul(Q_B, int'(blue)));
  assign qg_prod = OUT_W'(shift_add_mul(Q_G, int'(green)));

  generate
    if (I_B == Q_B + 1) begin : g_ib_reuse
      // The in-phase blue weight is one above the quadrature one: add one more copy of blue.
      assign ib_prod = qb_prod + blue_ext;
    end else begin : g_ib_own
      assign ib_prod = OUT_W'(shift_add_mul(I_B, int'(blue)));
    end
  endgenerate

endmodule

// File: rtl/yiq_level_mux.sv
module yiq_level_mux
  import rgb_yiq_pkg::*;
#(
  parameter int OUT_W       = 12,
  parameter int Y_OFFSET    = 640,
  parameter int BLANK_LEVEL = 544,
  parameter int SYNC_LEVEL  = 0,
  parameter int BURST_Y     = 1351,
  parameter int BURST_I     = 369,
  parameter int BURST_Q     = -351
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  yiq_mode_e               mode,
  input  logic                    sync_n,
  input  logic [OUT_W-1:0]        yr_prod,
  input  logic [OUT_W-1:0]        yg_prod,
  input  logic [OUT_W-1:0]        yb_prod,
  input  logic [OUT_W-1:0]        ir_prod,
  input  logic [OUT_W-1:0]        ig_prod,
  input  logic [OUT_W-1:0]        ib_prod,
  input  logic [OUT_W-1:0]        qr_prod,
  input  logic [OUT_W-1:0]        qg_prod,
  input  logic [OUT_W-1:0]        qb_prod,
  output logic [OUT_W-1:0]        luma,
  output logic signed [OUT_W-1:0] chroma_i,
  output logic signed [OUT_W-1:0] chroma_q
);

  localparam logic [OUT_W-1:0] OFFSET_C = OUT_W'(Y_OFFSET);
  localparam logic [OUT_W-1:0] BLANK_C  = OUT_W'(BLANK_LEVEL);
  localparam logic [OUT_W-1:0] SYNC_C   = OUT_W'(SYNC_LEVEL);
  localparam logic [OUT_W-1:0] BY_C     = OUT_W'(BURST_Y);
  localparam logic [OUT_W-1:0] BI_C     = OUT_W'(BURST_I);
  localparam logic [OUT_W-1:0] BQ_C     = OUT_W'(BURST_Q);

  logic [OUT_W-1:0] y_act, i_act, q_act, y_idle;
  logic [OUT_W-1:0] y_nxt, i_nxt, q_nxt;

  // Modular sums: the low OUT_W bits of the difference are the two's complement result.
  assign y_act  = yr_prod + yg_prod + yb_prod + OFFSET_C;
  assign i_act  = ir_prod - ig_prod - ib_prod;
  assign q_act  = qr_prod - qg_prod + qb_prod;
  assign y_idle = sync_n ? BLANK_C : SYNC_C;

  always_comb begin
    unique case (mode)
      MODE_BLANK:  begin y_nxt = y_idle; i_nxt = '0;    q_nxt = '0;    end
      MODE_BURST:  begin y_nxt = y_idle; i_nxt = BI_C;  q_nxt = BQ_C;  end
      MODE_ACTIVE: begin y_nxt = y_act;  i_nxt = i_act; q_nxt = q_act; end
      default:     begin y_nxt = BY_C;   i_nxt = BI_C;  q_nxt = BQ_C;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      luma     <= '0;
      chroma_i <= '0;
      chroma_q <= '0;
    end else begin
      luma     <= y_nxt;
      chroma_i <= i_nxt;
      chroma_q <= q_nxt;
    end
  end

endmodule

// File: rtl/rgb_yiq_encoder.sv
module rgb_yiq_encoder
  import rgb_yiq_pkg::*;
#(
  parameter int COMP_W      = 4,
  parameter int MUL_W       = 8,
  parameter int OUT_W       = 12,
  parameter int Y_R         = 27,
  parameter int Y_G         = 52,
  parameter int Y_B         = 10,
  parameter int I_R         = 76,
  parameter int I_G         = 35,
  parameter int I_B         = 41,
  parameter int Q_G         = 66,
  parameter int Q_B         = 40,
  parameter int Y_OFFSET    = 640,
  parameter int BLANK_LEVEL = 544,
  parameter int SYNC_LEVEL  = 0,
  parameter int BURST_R     = 9,
  parameter int BURST_G     = 9,
  parameter int BURST_B     = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [COMP_W-1:0]       red,
  input  logic [COMP_W-1:0]       green,
  input  logic [COMP_W-1:0]       blue,
  input  logic                    active,
  input  logic                    burst,
  input  logic                    sync_n,
  output logic [OUT_W-1:0]        luma,
  output logic signed [OUT_W-1:0] chroma_i,
  output logic signed [OUT_W-1:0] chroma_q
);

  // The quadrature red weight equals the luma red weight, so that product is shared.
  localparam int Q_R = Y_R;
  localparam int BURST_Y = weighted3(Y_R, Y_G, Y_B, BURST_R, BURST_G, BURST_B) + Y_OFFSET;
  localparam int BURST_I = weighted3(I_R, -I_G, -I_B, BURST_R, BURST_G, BURST_B);
  localparam int BURST_Q = weighted3(Q_R, -Q_G, Q_B, BURST_R, BURST_G, BURST_B);

  // Named internal events, visible to the bound checker.
  yiq_mode_e        sel_mode;
  logic [OUT_W-1:0] yr_p, yg_p, yb_p, ir_p, ig_p, ib_p, qg_p, qb_p;

  assign sel_mode = yiq_mode_e'({active, burst});

  yiq_mult_pair #(.COMP_W(COMP_W), .MUL_W(MUL_W), .OUT_W(OUT_W)) u_mul_green (
    .coef_a (MUL_W'(I_G)),
    .coef_b (MUL_W'(Y_G)),
    .sample (green),
    .prod_a (ig_p),
    .prod_b (yg_p)
  );

  yiq_mult_pair #(.COMP_W(COMP_W), .MUL_W(MUL_W), .OUT_W(OUT_W)) u_mul_red (
    .coef_a (MUL_W'(Y_R)),
    .coef_b (MUL_W'(I_R)),
    .sample (red),
    .prod_a (yr_p),
    .prod_b (ir_p)
  );

  yiq_const_terms #(
    .COMP_W(COMP_W), .OUT_W(OUT_W),
    .Y_B(Y_B), .Q_B(Q_B), .I_B(I_B), .Q_G(Q_G)
  ) u_terms (
    .green   (green),
    .blue    (blue),
    .yb_prod (yb_p),
    .qb_prod (qb_p),
    .ib_prod (ib_p),
    .qg_prod (qg_p)
  );

  yiq_level_mux #(
    .OUT_W(OUT_W), .Y_OFFSET(Y_OFFSET), .BLANK_LEVEL(BLANK_LEVEL),
    .SYNC_LEVEL(SYNC_LEVEL), .BURST_Y(BURST_Y), .BURST_I(BURST_I), .BURST_Q(BURST_Q)
  ) u_levels (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (sel_mode),
    .sync_n   (sync_n),
    .yr_prod  (yr_p),
    .yg_prod  (yg_p),
    .yb_prod  (yb_p),
    .ir_prod  (ir_p),
    .ig_prod  (ig_p),
    .ib_prod  (ib_p),
    .qr_prod  (yr_p),
    .qg_prod  (qg_p),
    .qb_prod  (qb_p),
    .luma     (luma),
    .chroma_i (chroma_i),
    .chroma_q (chroma_q)
  );

endmodule

// File: rtl/rgb_yiq_checker.sv
module rgb_yiq_checker #(
  parameter int OUT_W       = 12,
  parameter int Y_OFFSET    = 640,
  parameter int Y_MAX       = 1975,
  parameter int BLANK_LEVEL = 544,
  parameter int SYNC_LEVEL  = 0,
  parameter int BURST_Y     = 1351,
  parameter int BURST_I     = 369,
  parameter int BURST_Q     = -351
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic             burst,
  input logic             sync_n,
  input logic [OUT_W-1:0] luma,
  input logic [OUT_W-1:0] chroma_i,
  input logic [OUT_W-1:0] chroma_q
);

  localparam logic [OUT_W-1:0] BLANK_C = OUT_W'(BLANK_LEVEL);
  localparam logic [OUT_W-1:0] SYNC_C  = OUT_W'(SYNC_LEVEL);
  localparam logic [OUT_W-1:0] BY_C    = OUT_W'(BURST_Y);
  localparam logic [OUT_W-1:0] BI_C    = OUT_W'(BURST_I);
  localparam logic [OUT_W-1:0] BQ_C    = OUT_W'(BURST_Q);
  localparam logic [OUT_W-1:0] YLO_C   = OUT_W'(Y_OFFSET);
  localparam logic [OUT_W-1:0] YHI_C   = OUT_W'(Y_MAX);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (luma == '0 && chroma_i == '0 && chroma_q == '0)); // R2

  AST_BLANK_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !burst) |=> (chroma_i == '0 && chroma_q == '0 &&
                             luma == ($past(sync_n) ? BLANK_C : SYNC_C))); // R6

  AST_BURST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && burst) |=> (chroma_i == BI_C && chroma_q == BQ_C &&
                            luma == ($past(sync_n) ? BLANK_C : SYNC_C))); // R7

  AST_BURST_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && burst) |=> (luma == BY_C && chroma_i == BI_C && chroma_q == BQ_C)); // R8

  AST_LUMA_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !burst) |=> (luma >= YLO_C && luma <= YHI_C)); // R3

endmodule

bind rgb_yiq_encoder rgb_yiq_checker #(
  .OUT_W(OUT_W), .Y_OFFSET(Y_OFFSET),
  .Y_MAX(Y_OFFSET + (Y_R + Y_G + Y_B) * ((1 << COMP_W) - 1)),
  .BLANK_LEVEL(BLANK_LEVEL), .SYNC_LEVEL(SYNC_LEVEL),
  .BURST_Y(BURST_Y), .BURST_I(BURST_I), .BURST_Q(BURST_Q)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .active   (active),
  .burst    (burst),
  .sync_n   (sync_n),
  .luma     (luma),
  .chroma_i (chroma_i),
  .chroma_q (chroma_q)
);

// File: tb/tb_rgb_yiq_encoder.sv
module tb_rgb_yiq_encoder;

  typedef struct packed {
    logic       act;
    logic       bst;
    logic       syn;
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
    int         ey;
    int         ei;
    int         eq;
  } vec_t;

  // Hand-computed expectations from the requirements.
  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b1, 4'd15, 4'd15, 4'd15, 1975,    0,   15},
    '{1'b1, 1'b0, 1'b1, 4'd15, 4'd0,  4'd0,  1045, 1140,  405},
    '{1'b1, 1'b0, 1'b0, 4'd0,  4'd15, 4'd0,  1420, -525, -990},
    '{1'b1, 1'b0, 1'b1, 4'd0,  4'd0,  4'd15,  790, -615,  600},
    '{1'b1, 1'b0, 1'b0, 4'd0,  4'd0,  4'd0,   640,    0,    0},
    '{1'b1, 1'b0, 1'b1, 4'd3,  4'd5,  4'd7,  1051, -234,   31},
    '{1'b0, 1'b0, 1'b0, 4'd15, 4'd15, 4'd15,    0,    0,    0},
    '{1'b0, 1'b0, 1'b1, 4'd9,  4'd2,  4'd4,   544,    0,    0},
    '{1'b0, 1'b1, 1'b1, 4'd1,  4'd1,  4'd1,   544,  369, -351},
    '{1'b0, 1'b1, 1'b0, 4'd7,  4'd0,  4'd3,     0,  369, -351},
    '{1'b1, 1'b1, 1'b0, 4'd3,  4'd5,  4'd7,  1351,  369, -351}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  red = '0, green = '0, blue = '0;
  logic        active = 1'b0, burst = 1'b0, sync_n = 1'b0;
  logic [11:0] luma;
  logic signed [11:0] chroma_i, chroma_q;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rgb_yiq_encoder dut (
    .clk(clk), .rst_n(rst_n), .red(red), .green(green), .blue(blue),
    .active(active), .burst(burst), .sync_n(sync_n),
    .luma(luma), .chroma_i(chroma_i), .chroma_q(chroma_q)
  );

  // Reference: signed weights, direct multiplication.
  task automatic ref_model(input logic a, input logic bu, input logic s,
                           input int r, input int g, input int b,
                           output int y, output int i, output int q);
    int idle_y;
    idle_y = s ? 544 : 0;
    if (a && !bu) begin
      y = 27 * r + 52 * g + 10 * b + 640;
      i = 76 * r + (-35) * g + (-41) * b;
      q = 27 * r + (-66) * g + 40 * b;
    end else if (a && bu) begin
      y = 27 * 9 + 52 * 9 + 640; i = 76 * 9 - 35 * 9; q = 27 * 9 - 66 * 9;
    end else if (bu) begin
      y = idle_y; i = 76 * 9 - 35 * 9; q = 27 * 9 - 66 * 9;
    end else begin
      y = idle_y; i = 0; q = 0;
    end
  endtask

  function automatic string req_of(input logic a, input logic bu);
    if (a && !bu) return "R3/R4/R5/R9";
    if (a && bu)  return "R8/R9/R10";
    if (bu)       return "R7/R10";
    return "R6/R10";
  endfunction

  task automatic check(input string req, input int ey, input int ei, input int eq);
    int ay, ai, aq;
    ay = int'(luma);
    ai = int'(chroma_i);
    aq = int'(chroma_q);
    tests++;
    if (ay != ey || ai != ei || aq != eq) begin
      fails++;
      $display("FAIL %s: got y=%0d i=%0d q=%0d expected y=%0d i=%0d q=%0d",
               req, ay, ai, aq, ey, ei, eq);
    end
  endtask

  task automatic drive(input logic a, input logic bu, input logic s,
                       input logic [3:0] r, input logic [3:0] g, input logic [3:0] b);
    active = a; burst = bu; sync_n = s; red = r; green = g; blue = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog expired, got no finish expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ey, ei, eq;
    // R2: reset clears the outputs even with live inputs.
    drive(1'b1, 1'b0, 1'b1, 4'd15, 4'd15, 4'd15);
    repeat (3) @(negedge clk);
    check("R2", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", 1975, 0, 15);

    // Table of vectors, one per cycle.
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k].act, VEC[k].bst, VEC[k].syn, VEC[k].r, VEC[k].g, VEC[k].b);
      @(negedge clk);
      check(req_of(VEC[k].act, VEC[k].bst), VEC[k].ey, VEC[k].ei, VEC[k].eq);
    end

    // R1: new inputs do not appear before the rising edge.
    drive(1'b1, 1'b0, 1'b1, 4'd15, 4'd0, 4'd0);
    @(negedge clk);
    check("R1", 1045, 1140, 405);
    drive(1'b0, 1'b0, 1'b1, 4'd0, 4'd0, 4'd0);
    @(posedge clk);
    #1;
    check("R1", 544, 0, 0);
    drive(1'b1, 1'b0, 1'b1, 4'd0, 4'd0, 4'd15);
    @(negedge clk);
    check("R1", 544, 0, 0);
    @(posedge clk);
    #1;
    check("R1", 790, -615, 600);

    // R9: sync has no effect in active video.
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 4'd0, 4'd0, 4'd15);
    @(negedge clk);
    check("R9", 790, -615, 600);

    // R10: pixel values ignored in burst-only mode.
    drive(1'b0, 1'b1, 1'b1, 4'd15, 4'd15, 4'd15);
    @(negedge clk);
    check("R10", 544, 369, -351);

    // Exhaustive sweep: every flag combination, every pixel value.
    for (int f = 0; f < 8; f++) begin
      for (int p = 0; p < 4096; p++) begin
        drive(f[2], f[1], f[0], p[11:8], p[7:4], p[3:0]);
        @(negedge clk);
        ref_model(f[2], f[1], f[0], p[11:8], p[7:4], p[3:0], ey, ei, eq);
        check(req_of(f[2], f[1]), ey, ei, eq);
      end
    end

    // R2: reset in mid-run.
    drive(1'b1, 1'b1, 1'b1, 4'd5, 4'd5, 4'd5);
    rst_n = 1'b0;
    @(negedge clk);
    check("R2", 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", 1351, 369, -351);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule